// File: doc/BRIEF.md
# Raster-Op Rectangle Copy and Fill Engine

This block moves and fills rectangles in a frame buffer, one 128-bit word (a beat) at a time. For every destination beat it gathers three operands: a source word, a slice of a stored 8x8 pattern and the current destination word. A per-bit ternary logic function, picked by an 8-bit code, combines them. The result goes back to memory with one enable per byte, so pixels can be left untouched. The source can be a colour image in memory, a one-bit-per-pixel image that is widened to the target depth with two programmable colours, or a solid colour.

A job is described on the configuration inputs and launched with a one-cycle `start`. The engine samples the configuration at that moment and walks the rectangle row by row. When source and destination are both memory images and the destination lies above the source in the address space, it walks backwards from the last beat. An overlapping copy therefore reads every source word before it is overwritten. Memory is reached through a single request port: one request at a time, with reads completed by a data-valid strobe after any latency.

Top module: `blit_engine`

## Requirements
- R1: Each result bit equals bit `{P,S,D}` of `cfg_rop`, where P (index bit 2), S (bit 1) and D (bit 0) are the pattern, source and destination bits at that position.
- R2: The pattern store holds 8 rows of 256 bits, each written as two 128-bit halves (`pat_half` 0 = bits 127:0). Pattern pixel c of row r sits at byte c*B of row r, where B is the pixel size in bytes. A destination pixel at column x, row y (both counted from the rectangle's first pixel) uses pattern pixel x mod 8 of row y mod 8.
- R3: `cfg_bpp` selects the pixel size: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits. A beat holds 16, 8 or 4 pixels, and pixel i of a beat occupies bytes i*B to i*B+B-1.
- R4: With `cfg_src_mode` = 1 (monochrome), bit i of each source word gives pixel i of the beat. A 1 selects the low B bytes of `cfg_fg` and a 0 selects those of `cfg_bg`.
- R5: With `cfg_src_mode` = 2 (solid), every source pixel is the low B bytes of `cfg_fg`, and no source read is issued. `cfg_src_mode` = 0 takes the source word as colour data.
- R6: `cfg_trans` = 0 enables every byte. Mode 1 disables the bytes of each pixel whose source colour equals the low B bytes of `cfg_key`. Mode 2 disables the bytes of each pixel whose source colour differs from it.
- R7: Beat b of row y is read and written at byte address base + y*pitch + 16*b, using the source or destination base and pitch. Each destination beat of the rectangle (width in beats, height in rows) is written exactly once, and nothing else is written.
- R8: When the source mode is 0 and `cfg_dst_base` > `cfg_src_base`, the walk starts at the last beat of the last row and runs backwards. Otherwise it starts at beat 0 of row 0 and runs forwards. With equal pitches, an overlapping copy gives the same result as a copy from the unmodified source.
- R9: `done` rises after the last write and stays high until the next accepted `start`. `irq` is high for exactly one cycle per job. `busy` is high while a job runs.
- R10: A `start` while `busy` is high is ignored, and the running job keeps its sampled configuration.
- R11: `mem_req` is a one-cycle pulse with a 16-byte aligned address, and at most one read is outstanding.
- R12: A job with zero width or zero height writes nothing and still raises `done` and one `irq` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, sampled when idle |
| cfg_src_base | input | 32 | Source byte address of row 0, beat 0 |
| cfg_dst_base | input | 32 | Destination byte address of row 0, beat 0 |
| cfg_src_pitch | input | 16 | Source line stride in bytes |
| cfg_dst_pitch | input | 16 | Destination line stride in bytes |
| cfg_width | input | 12 | Rectangle width in 128-bit beats |
| cfg_height | input | 12 | Rectangle height in rows |
| cfg_bpp | input | 2 | Pixel size code |
| cfg_rop | input | 8 | Ternary logic function code |
| cfg_src_mode | input | 2 | 0 colour memory, 1 monochrome memory, 2 solid |
| cfg_trans | input | 2 | 0 opaque, 1 skip key colour, 2 keep only key colour |
| cfg_fg | input | 32 | Foreground or solid colour |
| cfg_bg | input | 32 | Background colour for monochrome expansion |
| cfg_key | input | 32 | Transparency key colour |
| pat_we | input | 1 | Pattern store write strobe |
| pat_row | input | 3 | Pattern row being written |
| pat_half | input | 1 | Pattern row half being written |
| pat_wdata | input | 128 | Pattern write data |
| mem_req | output | 1 | Memory request pulse |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request byte address |
| mem_wdata | output | 128 | Write data |
| mem_wbe | output | 16 | Write byte enables |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 128 | Read data |
| busy | output | 1 | Job in progress |
| done | output | 1 | Last job finished |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is an overlapping copy in which a wrong walk order would read a source word that an earlier write has already replaced. The stimulus sets up a destination one row and one beat past the source with equal pitch, and then the mirror case. Every write is compared against results computed from a snapshot taken before the job, so a forward walk in the first case corrupts the written data. Read latency is varied from request to request. A second `start` with a changed code is fired into a running job.

// File: rtl/blit_pkg.sv
`timescale 1ns/1ps
package blit_pkg;
  typedef enum logic [1:0] {SRC_MEM = 2'd0, SRC_MONO = 2'd1, SRC_SOLID = 2'd2} src_mode_e;
  typedef enum logic [1:0] {TR_OPAQUE = 2'd0, TR_SKIP_KEY = 2'd1, TR_KEEP_KEY = 2'd2} trans_e;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SRC, ST_SWAIT, ST_DST, ST_DWAIT, ST_WR, ST_STEP
  } blit_state_e;

  // Pixel size code 3 is undefined; treat it as 32 bits.
  function automatic logic [1:0] bpp_clamp(input logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction
endpackage

// File: rtl/blit_pattern_store.sv
`timescale 1ns/1ps
module blit_pattern_store #(
  parameter int DATA_W = 128,
  parameter int ROWS   = 8
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [$clog2(ROWS)-1:0]  wr_row,
  input  logic                     wr_half,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [$clog2(ROWS)-1:0]  rd_row,
  input  logic                     rd_odd_beat,
  input  logic [1:0]               bpp,
  output logic [DATA_W-1:0]        pat_beat
);
  import blit_pkg::*;
  localparam int DEPTH = ROWS * 2;
  localparam int HALF  = DATA_W / 2;

  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] lo_word, hi_word;

  always_ff @(posedge clk) begin
    if (wr_en) store[{wr_row, wr_half}] <= wr_data;
  end

  assign lo_word = store[{rd_row, 1'b0}];
  assign hi_word = store[{rd_row, 1'b1}];

  // A beat starts on a multiple of 16, 8 or 4 pixels, so only the 32-bit
  // case needs to know which half of the pattern row it lands on.
  always_comb begin
    unique case (bpp_clamp(bpp))
      2'd0:    pat_beat = {lo_word[HALF-1:0], lo_word[HALF-1:0]};
      2'd1:    pat_beat = lo_word;
      default: pat_beat = rd_odd_beat ? hi_word : lo_word;
    endcase
  end
endmodule

// File: rtl/blit_src_shaper.sv
`timescale 1ns/1ps
module blit_src_shaper #(
  parameter int DATA_W = 128,
  parameter int PIX_W  = 32
) (
  input  logic [DATA_W-1:0]   src_word,
  input  logic [1:0]          bpp,
  input  logic [1:0]          src_mode,
  input  logic [1:0]          trans_mode,
  input  logic [PIX_W-1:0]    fg,
  input  logic [PIX_W-1:0]    bg,
  input  logic [PIX_W-1:0]    key,
  output logic [DATA_W-1:0]   src_op,
  output logic [DATA_W/8-1:0] byte_en
);
  import blit_pkg::*;
  localparam int NB = DATA_W / 8;

  logic [1:0]    bsz;
  logic [NB-1:0] key_eq;
  logic [NB-1:0] pix_match;

  assign bsz = bpp_clamp(bpp);

  always_comb begin
    int pix;
    int sel;
    logic [PIX_W-1:0] colour;
    logic [7:0] b;
    src_op = '0;
    key_eq = '0;
    for (int k = 0; k < NB; k++) begin
      pix    = k >> bsz;
      sel    = k & ((1 << bsz) - 1);
      colour = src_word[pix] ? fg : bg;
      unique case (src_mode)
        SRC_MONO:  b = colour[sel*8 +: 8];
        SRC_SOLID: b = fg[sel*8 +: 8];
        default:   b = src_word[k*8 +: 8];
      endcase
      src_op[k*8 +: 8] = b;
      key_eq[k]        = (b == key[sel*8 +: 8]);
    end
  end

  always_comb begin
    int grp;
    logic m;
    pix_match = '0;
    for (int k = 0; k < NB; k++) begin
      grp = k & ~((1 << bsz) - 1);
      m   = 1'b1;
      for (int j = 0; j < 4; j++) begin
        if (j < (1 << bsz)) m = m & key_eq[grp + j];
      end
      pix_match[k] = m;
    end
  end

  always_comb begin
    unique case (trans_mode)
      TR_SKIP_KEY: byte_en = ~pix_match;
      TR_KEEP_KEY: byte_en = pix_match;
      default:     byte_en = '1;
    endcase
  end
endmodule

// File: rtl/blit_rop_unit.sv
`timescale 1ns/1ps
module blit_rop_unit #(
  parameter int DATA_W = 128
) (
  input  logic [7:0]        rop,
  input  logic [DATA_W-1:0] pat,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] dst,
  output logic [DATA_W-1:0] result
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign result[i] = rop[{pat[i], src[i], dst[i]}];
  end
endmodule

// File: rtl/blit_engine.sv
`timescale 1ns/1ps
module blit_engine #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 128,
  parameter int DIM_W   = 12,
  parameter int PITCH_W = 16,
  parameter int PIX_W   = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [ADDR_W-1:0]    cfg_src_base,
  input  logic [ADDR_W-1:0]    cfg_dst_base,
  input  logic [PITCH_W-1:0]   cfg_src_pitch,
  input  logic [PITCH_W-1:0]   cfg_dst_pitch,
  input  logic [DIM_W-1:0]     cfg_width,
  input  logic [DIM_W-1:0]     cfg_height,
  input  logic [1:0]           cfg_bpp,
  input  logic [7:0]           cfg_rop,
  input  logic [1:0]           cfg_src_mode,
  input  logic [1:0]           cfg_trans,
  input  logic [PIX_W-1:0]     cfg_fg,
  input  logic [PIX_W-1:0]     cfg_bg,
  input  logic [PIX_W-1:0]     cfg_key,
  input  logic                 pat_we,
  input  logic [2:0]           pat_row,
  input  logic                 pat_half,
  input  logic [DATA_W-1:0]    pat_wdata,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [DATA_W-1:0]    mem_wdata,
  output logic [DATA_W/8-1:0]  mem_wbe,
  input  logic                 mem_rvalid,
  input  logic [DATA_W-1:0]    mem_rdata,
  output logic                 busy,
  output logic                 done,
  output logic                 irq
);
  import blit_pkg::*;
  localparam int BEAT_BYTES = DATA_W / 8;
  localparam int BEAT_SHIFT = $clog2(BEAT_BYTES);

  blit_state_e          state;
  logic [ADDR_W-1:0]    src_row, dst_row;
  logic [DIM_W-1:0]     y_q, bx_q, w_q, h_q;
  logic [PITCH_W-1:0]   sp_q, dp_q;
  logic [1:0]           bpp_q, smode_q, trans_q;
  logic [7:0]           rop_q;
  logic [PIX_W-1:0]     fg_q, bg_q, key_q;
  logic                 rev_q;
  logic [DATA_W-1:0]    s_word, d_word;

  logic [ADDR_W-1:0]    beat_off, src_addr, dst_addr;
  logic [DATA_W-1:0]    pat_beat, src_op, rop_out;
  logic [BEAT_BYTES-1:0] src_be;
  logic                 last_beat, row_end;
  logic                 rev_n;
  logic [ADDR_W-1:0]    h_last;

  assign beat_off = ADDR_W'(bx_q) << BEAT_SHIFT;
  assign src_addr = src_row + beat_off;
  assign dst_addr = dst_row + beat_off;
  assign busy     = (state != ST_IDLE);

  assign row_end   = rev_q ? (bx_q == '0) : (bx_q == w_q - 1'b1);
  assign last_beat = row_end && (rev_q ? (y_q == '0) : (y_q == h_q - 1'b1));

  assign rev_n  = (cfg_src_mode == SRC_MEM) && (cfg_dst_base > cfg_src_base);
  assign h_last = ADDR_W'(cfg_height) - 1'b1;

  blit_pattern_store #(.DATA_W(DATA_W), .ROWS(8)) u_pat (
    .clk        (clk),
    .wr_en      (pat_we),
    .wr_row     (pat_row),
    .wr_half    (pat_half),
    .wr_data    (pat_wdata),
    .rd_row     (y_q[2:0]),
    .rd_odd_beat(bx_q[0]),
    .bpp        (bpp_q),
    .pat_beat   (pat_beat)
  );

  blit_src_shaper #(.DATA_W(DATA_W), .PIX_W(PIX_W)) u_shape (
    .src_word  (s_word),
    .bpp       (bpp_q),
    .src_mode  (smode_q),
    .trans_mode(trans_q),
    .fg        (fg_q),
    .bg        (bg_q),
    .key       (key_q),
    .src_op    (src_op),
    .byte_en   (src_be)
  );

  blit_rop_unit #(.DATA_W(DATA_W)) u_rop (
    .rop   (rop_q),
    .pat   (pat_beat),
    .src   (src_op),
    .dst   (d_word),
    .result(rop_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      src_row   <= '0;
      dst_row   <= '0;
      y_q       <= '0;
      bx_q      <= '0;
      w_q       <= '0;
      h_q       <= '0;
      sp_q      <= '0;
      dp_q      <= '0;
      bpp_q     <= '0;
      smode_q   <= '0;
      trans_q   <= '0;
      rop_q     <= '0;
      fg_q      <= '0;
      bg_q      <= '0;
      key_q     <= '0;
      rev_q     <= 1'b0;
      s_word    <= '0;
      d_word    <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_wbe   <= '0;
      done      <= 1'b0;
      irq       <= 1'b0;
    end else begin
      irq     <= 1'b0;
      mem_req <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            if (cfg_width == '0 || cfg_height == '0) begin
              done <= 1'b1;
              irq  <= 1'b1;
            end else begin
              done    <= 1'b0;
              w_q     <= cfg_width;
              h_q     <= cfg_height;
              sp_q    <= cfg_src_pitch;
              dp_q    <= cfg_dst_pitch;
              bpp_q   <= cfg_bpp;
              smode_q <= cfg_src_mode;
              trans_q <= cfg_trans;
              rop_q   <= cfg_rop;
              fg_q    <= cfg_fg;
              bg_q    <= cfg_bg;
              key_q   <= cfg_key;
              rev_q   <= rev_n;
              if (rev_n) begin
                y_q     <= cfg_height - 1'b1;
                bx_q    <= cfg_width - 1'b1;
                src_row <= cfg_src_base + h_last * ADDR_W'(cfg_src_pitch);
                dst_row <= cfg_dst_base + h_last * ADDR_W'(cfg_dst_pitch);
              end else begin
                y_q     <= '0;
                bx_q    <= '0;
                src_row <= cfg_src_base;
                dst_row <= cfg_dst_base;
              end
              state <= ST_SRC;
            end
          end
        end
        ST_SRC: begin
          if (smode_q == SRC_SOLID) begin
            state <= ST_DST;
          end else begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= src_addr;
            state    <= ST_SWAIT;
          end
        end
        ST_SWAIT: begin
          if (mem_rvalid) begin
            s_word <= mem_rdata;
            state  <= ST_DST;
          end
        end
        ST_DST: begin
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= dst_addr;
          state    <= ST_DWAIT;
        end
        ST_DWAIT: begin
          if (mem_rvalid) begin
            d_word <= mem_rdata;
            state  <= ST_WR;
          end
        end
        ST_WR: begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= dst_addr;
          mem_wdata <= rop_out;
          mem_wbe   <= src_be;
          state     <= ST_STEP;
        end
        ST_STEP: begin
          mem_we <= 1'b0;
          if (last_beat) begin
            done  <= 1'b1;
            irq   <= 1'b1;
            state <= ST_IDLE;
          end else begin
            if (row_end) begin
              if (rev_q) begin
                y_q     <= y_q - 1'b1;
                bx_q    <= w_q - 1'b1;
                src_row <= src_row - ADDR_W'(sp_q);
                dst_row <= dst_row - ADDR_W'(dp_q);
              end else begin
                y_q     <= y_q + 1'b1;
                bx_q    <= '0;
                src_row <= src_row + ADDR_W'(sp_q);
                dst_row <= dst_row + ADDR_W'(dp_q);
              end
            end else begin
              bx_q <= rev_q ? bx_q - 1'b1 : bx_q + 1'b1;
            end
            state <= ST_SRC;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_req_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
  assert_addr_aligned_R11: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[BEAT_SHIFT-1:0] == '0));
  assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_beat_range_R7: assert property (@(posedge clk) disable iff (rst)
    busy |-> (bx_q < w_q && y_q < h_q));
  assert_opaque_full_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && trans_q == TR_OPAQUE) |-> (&mem_wbe));
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(rop_q));
endmodule

// File: tb/blit_engine_tb_top.sv
`timescale 1ns/1ps
module blit_engine_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst, start;
  logic [31:0]  cfg_src_base, cfg_dst_base;
  logic [15:0]  cfg_src_pitch, cfg_dst_pitch;
  logic [11:0]  cfg_width, cfg_height;
  logic [1:0]   cfg_bpp, cfg_src_mode, cfg_trans;
  logic [7:0]   cfg_rop;
  logic [31:0]  cfg_fg, cfg_bg, cfg_key;
  logic         pat_we, pat_half;
  logic [2:0]   pat_row;
  logic [127:0] pat_wdata;
  logic         mem_req, mem_we, mem_rvalid;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata, mem_rdata;
  logic [15:0]  mem_wbe;
  logic         busy, done, irq;

  blit_engine dut_i (
    .clk(clk), .rst(rst), .start(start),
    .cfg_src_base(cfg_src_base), .cfg_dst_base(cfg_dst_base),
    .cfg_src_pitch(cfg_src_pitch), .cfg_dst_pitch(cfg_dst_pitch),
    .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_bpp(cfg_bpp),
    .cfg_rop(cfg_rop), .cfg_src_mode(cfg_src_mode), .cfg_trans(cfg_trans),
    .cfg_fg(cfg_fg), .cfg_bg(cfg_bg), .cfg_key(cfg_key),
    .pat_we(pat_we), .pat_row(pat_row), .pat_half(pat_half), .pat_wdata(pat_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wbe(mem_wbe), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .irq(irq)
  );

  logic [127:0] mem  [0:1023];
  logic [127:0] snap [0:1023];
  logic [127:0] expw [0:1023];
  logic [15:0]  expbe[0:1023];
  bit           exp_on[0:1023];
  bit           seen  [0:1023];
  logic [7:0]   patb [0:7][0:31];

  int errors = 0;
  int checks = 0;
  int seed = 32'h1234_5678;
  bit job_active = 0;
  int wr_cnt = 0;
  int irq_cnt = 0;
  logic [31:0] exp_first;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd32();
    seed = seed * 1103515245 + 12345;
    return {seed[23:8], seed[30:15]};
  endfunction

  function automatic logic [7:0] src_byte(input logic [127:0] sw, input int k, input int bpp,
                                          input int smode, input logic [31:0] fg, input logic [31:0] bg);
    int bsz = 1 << bpp;
    int p = k / bsz;
    int bs = k % bsz;
    if (smode == 1) return sw[p] ? fg[bs*8 +: 8] : bg[bs*8 +: 8];
    if (smode == 2) return fg[bs*8 +: 8];
    return sw[k*8 +: 8];
  endfunction

  // Memory responder and per-clock write comparison.
  int rd_delay = -1;
  int lat_sel = 0;
  logic [9:0] rd_idx;
  initial begin
    mem_rvalid = 0;
    mem_rdata  = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 0;
      if (rst) begin
        rd_delay = -1;
      end else begin
        if (irq) irq_cnt++;
        if (mem_req && !mem_we) begin
          check(rd_delay < 0, "R11", "second read while one outstanding", 128'(rd_delay), 128'(-1));
          rd_idx = mem_addr[13:4];
          rd_delay = lat_sel % 3;
          lat_sel++;
        end
        if (rd_delay == 0) begin
          mem_rvalid = 1;
          mem_rdata = mem[rd_idx];
          rd_delay = -1;
        end else if (rd_delay > 0) begin
          rd_delay--;
        end
        if (mem_req && mem_we) begin
          automatic int idx = mem_addr[13:4];
          automatic logic [127:0] m = '0;
          for (int k = 0; k < 16; k++) if (expbe[idx][k]) m[k*8 +: 8] = 8'hff;
          check(job_active && exp_on[idx] && !seen[idx], "R7", "write to unexpected or repeated word",
                128'(mem_addr), 128'(idx));
          if (wr_cnt == 0)
            check(mem_addr == exp_first, "R8", "first written address", 128'(mem_addr), 128'(exp_first));
          check(mem_wbe == expbe[idx], "R6", "byte enables", 128'(mem_wbe), 128'(expbe[idx]));
          check((mem_wdata & m) == (expw[idx] & m), "R1", "write data", mem_wdata & m, expw[idx] & m);
          seen[idx] = 1;
          wr_cnt++;
          for (int k = 0; k < 16; k++) if (mem_wbe[k]) mem[idx][k*8 +: 8] = mem_wdata[k*8 +: 8];
        end
      end
    end
  end

  task automatic load_pattern();
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 32; c++) patb[r][c] = rnd32() & 8'hff;
    for (int r = 0; r < 8; r++) begin
      for (int h = 0; h < 2; h++) begin
        @(negedge clk);
        pat_we = 1; pat_row = 3'(r); pat_half = h[0];
        for (int k = 0; k < 16; k++) pat_wdata[k*8 +: 8] = patb[r][h*16 + k];
      end
    end
    @(negedge clk);
    pat_we = 0;
  endtask

  task automatic compute_expected();
    int bsz = 1 << cfg_bpp;
    for (int i = 0; i < 1024; i++) begin
      snap[i] = mem[i]; expw[i] = mem[i]; expbe[i] = '0; exp_on[i] = 0; seen[i] = 0;
    end
    for (int y = 0; y < int'(cfg_height); y++) begin
      for (int b = 0; b < int'(cfg_width); b++) begin
        automatic int si = ((cfg_src_base + y*cfg_src_pitch + b*16) >> 4) & 1023;
        automatic int di = ((cfg_dst_base + y*cfg_dst_pitch + b*16) >> 4) & 1023;
        automatic logic [127:0] sw = snap[si];
        automatic logic [127:0] dw = snap[di];
        automatic logic [127:0] rw = '0;
        automatic logic [15:0] be = '0;
        for (int k = 0; k < 16; k++) begin
          automatic int p = k / bsz;
          automatic int bs = k % bsz;
          automatic int x = b * (16 / bsz) + p;
          automatic logic [7:0] sb = src_byte(sw, k, cfg_bpp, cfg_src_mode, cfg_fg, cfg_bg);
          automatic logic [7:0] pb = patb[y % 8][(x % 8) * bsz + bs];
          automatic logic [7:0] db = dw[k*8 +: 8];
          automatic bit match = 1;
          for (int j = 0; j < 8; j++) rw[k*8 + j] = cfg_rop[{pb[j], sb[j], db[j]}];
          for (int j = 0; j < bsz; j++)
            if (src_byte(sw, p*bsz + j, cfg_bpp, cfg_src_mode, cfg_fg, cfg_bg) != cfg_key[j*8 +: 8]) match = 0;
          be[k] = (cfg_trans == 1) ? !match : (cfg_trans == 2) ? match : 1'b1;
          if (be[k]) expw[di][k*8 +: 8] = rw[k*8 +: 8];
        end
        expbe[di] = be;
        exp_on[di] = 1;
      end
    end
    if (cfg_src_mode == 0 && cfg_dst_base > cfg_src_base)
      exp_first = cfg_dst_base + (cfg_height - 1) * cfg_dst_pitch + (cfg_width - 1) * 16;
    else
      exp_first = cfg_dst_base;
  endtask

  task automatic run_job(input string req, input bit poke);
    automatic logic [7:0] rop_keep = cfg_rop;
    automatic int guard = 0;
    automatic int mism = 0;
    automatic int expected_writes = int'(cfg_width) * int'(cfg_height);
    compute_expected();
    @(negedge clk);
    wr_cnt = 0; irq_cnt = 0; job_active = 1;
    start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      repeat (6) @(negedge clk);
      check(busy == 1, "R10", "busy during job", 128'(busy), 128'(1));
      cfg_rop = ~rop_keep;
      start = 1;
      @(negedge clk);
      start = 0;
    end
    while (!done && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
    job_active = 0;
    cfg_rop = rop_keep;
    check(done == 1 && busy == 0, "R9", {req, " done held, busy low"}, 128'({done, busy}), 128'(2'b10));
    check(irq_cnt == 1, "R9", {req, " irq pulse count"}, 128'(irq_cnt), 128'(1));
    check(wr_cnt == expected_writes, "R7", {req, " write count"}, 128'(wr_cnt), 128'(expected_writes));
    for (int i = 0; i < 1024; i++) if (mem[i] !== expw[i]) begin
      if (mism == 0) $display("  word %0d differs in %s", i, req);
      mism++;
    end
    check(mism == 0, req, "final memory image", 128'(mism), 128'(0));
  endtask

  task automatic set_job(input int sb, input int db, input int sp, input int dp, input int w,
                         input int h, input int bpp, input int rop, input int sm, input int tr);
    cfg_src_base = 32'(sb); cfg_dst_base = 32'(db);
    cfg_src_pitch = 16'(sp); cfg_dst_pitch = 16'(dp);
    cfg_width = 12'(w); cfg_height = 12'(h); cfg_bpp = 2'(bpp);
    cfg_rop = 8'(rop); cfg_src_mode = 2'(sm); cfg_trans = 2'(tr);
  endtask

  // Fill a source rectangle where every third pixel carries the key colour.
  task automatic fill_keyed(input int base, input int pitch, input int w, input int h, input int bpp);
    int bsz = 1 << bpp;
    int n = 0;
    for (int y = 0; y < h; y++)
      for (int b = 0; b < w; b++) begin
        automatic int idx = ((base + y*pitch + b*16) >> 4) & 1023;
        for (int p = 0; p < 16 / bsz; p++) begin
          automatic logic [31:0] v = (n % 3 == 0) ? cfg_key : rnd32();
          for (int j = 0; j < bsz; j++) mem[idx][(p*bsz + j)*8 +: 8] = v[j*8 +: 8];
          n++;
        end
      end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog run did not complete actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1; start = 0; pat_we = 0; pat_row = '0; pat_half = 0; pat_wdata = '0;
    cfg_fg = 32'hA1B2C3D4; cfg_bg = 32'h0F1E2D3C; cfg_key = 32'h5566_7788;
    set_job(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 1024; i++) mem[i] = {rnd32(), rnd32(), rnd32(), rnd32()};
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(busy == 0 && done == 0 && irq == 0 && mem_req == 0, "R9", "reset state",
          128'({busy, done, irq, mem_req}), 128'(0));
    load_pattern();

    set_job(32'h0000, 32'h0800, 32'h100, 32'h100, 3, 4, 0, 8'hCC, 0, 0); run_job("R7", 0);
    set_job(32'h0000, 32'h1000, 32'h080, 32'h080, 4, 10, 2, 8'hF0, 2, 0); run_job("R2", 0);
    set_job(32'h0000, 32'h1800, 32'h100, 32'h100, 2, 3, 1, 8'hB8, 0, 0); run_job("R3", 0);
    set_job(32'h0000, 32'h1C00, 32'h100, 32'h100, 2, 3, 1, 8'hCC, 1, 0); run_job("R4", 0);
    set_job(32'h0040, 32'h2000, 32'h100, 32'h100, 3, 2, 0, 8'h6A, 1, 0); run_job("R4", 0);
    set_job(32'h0000, 32'h2400, 32'h100, 32'h100, 2, 3, 2, 8'h66, 2, 0); run_job("R5", 0);
    set_job(32'h2800, 32'h2C00, 32'h100, 32'h100, 2, 3, 1, 8'hCC, 0, 1);
    fill_keyed(32'h2800, 32'h100, 2, 3, 1); run_job("R6", 0);
    set_job(32'h2800, 32'h2C00, 32'h100, 32'h100, 2, 3, 2, 8'hCC, 0, 2);
    fill_keyed(32'h2800, 32'h100, 2, 3, 2); run_job("R6", 0);
    set_job(32'h3000, 32'h3110, 32'h100, 32'h100, 4, 5, 0, 8'hCC, 0, 0); run_job("R8", 0);
    set_job(32'h3810, 32'h3800, 32'h100, 32'h100, 4, 4, 1, 8'hCC, 0, 0); run_job("R8", 0);
    set_job(32'h0000, 32'h0800, 32'h100, 32'h100, 3, 3, 0, 8'h96, 0, 0); run_job("R10", 1);
    set_job(32'h0000, 32'h1000, 32'h100, 32'h100, 2, 2, 0, 8'h5A, 2, 0); run_job("R1", 0);
    set_job(32'h0000, 32'h1000, 32'h100, 32'h100, 0, 3, 0, 8'hFF, 0, 0); run_job("R12", 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule